// File: doc/BRIEF.md
# Self-Correcting Finite-State Machine with Present-State Selection

This block is a small clocked state machine hardened against single faults by keeping two copies of its next-state and output logic, each with its own state register. The first copy is a plain implementation. The second copy builds every bit from its own cone of logic, with no sharing between bits, and a separate parity predictor forecasts the even parity of that copy's next state and of its outputs. The predicted state parity is stored in a register that sits next to the second state register.

Every cycle, before any logic uses the stored states, two flags are formed on them. Flag A reports that the two present states differ. Flag B reports that the second present state disagrees with its stored parity. A 2-to-1 selector then picks one present state, and both logic copies compute from it. The outputs of the two copies pass through the same kind of selector, with their own pair of flags. An upset in either state register, or a fault in either logic copy or in the predictor, is therefore masked in the same cycle, and no cycle is spent on recomputation. The price is a longer path: the flags sit in series with the next-state logic.

The example machine has 2^SW states, encoded in binary, with idle at zero. It has one input bit and two output bits. Test inputs can flip register bits, logic-copy result bits and predictor bits for one cycle at a time.

Top module: `ft_state_machine`

## Requirements
- R1: While `rst_n` is low, both state registers hold the idle encoding 0 and the stored parity holds the even parity of 0. During and right after reset, `cur_state` is 0 and all four flags are 0.
- R2: For the fault-free state S and input `in_bit`, the next state is (S+1) mod 2^SW when `in_bit`=1, and S rotated left by one place (the top bit moves into bit 0) when `in_bit`=0. Idle with `in_bit`=0 stays idle.
- R3: `out_bits[1]` = S[SW-1] XOR `in_bit` and `out_bits[0]` = S[0] AND `in_bit`. Both are functions of the selected present state S and the current input, and appear in the same cycle.
- R4: `st_flag_a` is 1 exactly when register 1 XOR `inj_st1` differs from register 2 XOR `inj_st2`.
- R5: `st_flag_b` is 1 exactly when the even parity of register 2 XOR `inj_st2` differs from the stored parity bit. With NG groups, bit i belongs to group i mod NG.
- R6: The selected present state `cur_state` is register 2's value when A=1 and B=0. In every other case, it is register 1's value. After a single-bit flip on `inj_st1` or on `inj_st2`, `cur_state` and `out_bits` still equal the fault-free values in that cycle.
- R7: The output flags are formed in the same way on the two output vectors and the predicted output parity. `out_bits` takes copy 2's outputs only when A=1 and B=0, and copy 1's outputs otherwise. A single flipped output bit in either copy (`inj_lg1`/`inj_lg2` bits SW+1..SW) leaves `out_bits` correct.
- R8: After a cycle with no logic or predictor fault injected, both registers and the stored parity hold the fault-free next state at the next edge, so a register upset leaves all flags at 0 in the following cycle.
- R9: A single flipped next-state bit in one copy (`inj_lg1`/`inj_lg2` bits SW-1..0) is stored only in that copy's register. In the next cycle it is masked by the selection, and it is cleared by the edge after that.
- R10: A flipped predictor bit (`inj_pred` bit 0 for the state group, bit NG for the outputs) raises only the matching B flag, and `cur_state` and `out_bits` stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_bit | input | 1 | Machine input |
| inj_st1 | input | SW | XOR mask on register 1's output |
| inj_st2 | input | SW | XOR mask on register 2's output |
| inj_lg1 | input | SW+2 | XOR mask on copy 1 results: next state in low bits, outputs above |
| inj_lg2 | input | SW+2 | XOR mask on copy 2 results, same layout |
| inj_pred | input | NG+1 | XOR mask on predictor: state groups low, output parity at bit NG |
| cur_state | output | SW | Selected present state |
| out_bits | output | 2 | Selected machine outputs |
| st_flag_a | output | 1 | Present states disagree |
| st_flag_b | output | 1 | Register 2 fails its stored parity |
| out_flag_a | output | 1 | Output vectors disagree |
| out_flag_b | output | 1 | Copy 2 outputs fail predicted parity |

## Verification
`cur_state`, `out_bits` and the four flags depend combinationally on the registers and the current inputs. The bench therefore drives each cycle's stimulus at the falling edge and compares these results one time unit later, still within the same cycle. Faults that get stored (R8, R9, and the state half of R10) appear only after the following rising edge. The bench's register model moves forward at that edge, and the effect is compared in the next cycle's sample window. Random faults are only injected when the model's registers are clean, which keeps every case a single-fault case.

// File: rtl/ftfsm_pkg.sv
package ftfsm_pkg;

   // number of machine output bits
   localparam int OUT_W = 2;

   // diagnosis formed from {flag_a, flag_b}
   typedef enum logic [1:0] {
      PICK_AGREE     = 2'b00,
      PICK_PREDBAD   = 2'b01,
      PICK_FIRSTBAD  = 2'b10,
      PICK_SECONDBAD = 2'b11
   } pick_e;

endpackage

// File: rtl/ftfsm_core_ref.sv
module ftfsm_core_ref #(
   parameter int SW = 3
) (
   input  logic [SW-1:0]               cur_s,
   input  logic                        x_in,
   output logic [SW-1:0]               nxt_s,
   output logic [ftfsm_pkg::OUT_W-1:0] outs
);
   // area-oriented copy: shared adder, shared terms
   always_comb begin
      if (x_in) nxt_s = cur_s + 1'b1;
      else      nxt_s = {cur_s[SW-2:0], cur_s[SW-1]};
      outs = {cur_s[SW-1] ^ x_in, cur_s[0] & x_in};
   end
endmodule

// File: rtl/ftfsm_core_split.sv
module ftfsm_core_split #(
   parameter int SW = 3
) (
   input  logic [SW-1:0]               cur_s,
   input  logic                        x_in,
   output logic [SW-1:0]               nxt_s,
   output logic [ftfsm_pkg::OUT_W-1:0] outs
);
   // each bit built from its own cone, no shared carry chain
   for (genvar i = 0; i < SW; i++) begin : g_bit
      localparam logic [SW-1:0] LOW_MASK = SW'((64'd1 << i) - 64'd1);
      logic low_all_one;
      assign low_all_one = &(cur_s | ~LOW_MASK);
      assign nxt_s[i] = x_in ? (cur_s[i] ^ low_all_one) : cur_s[(i + SW - 1) % SW];
   end

   assign outs[1] = x_in ? ~cur_s[SW-1] : cur_s[SW-1];
   assign outs[0] = cur_s[0] ? x_in : 1'b0;
endmodule

// File: rtl/ftfsm_par_pred.sv
module ftfsm_par_pred #(
   parameter int SW = 3,
   parameter int NG = 1
) (
   input  logic [SW-1:0] cur_s,
   input  logic          x_in,
   output logic [NG-1:0] st_par,
   output logic          out_par
);
   // predicts even parity of each next-state group and of the outputs
   always_comb begin
      logic run;
      logic inc_bit;
      st_par = '0;
      run    = 1'b1;
      for (int i = 0; i < SW; i++) begin
         inc_bit = cur_s[i] ^ run;
         run     = run & cur_s[i];
         st_par[i % NG] = st_par[i % NG] ^ (x_in ? inc_bit : cur_s[(i + SW - 1) % SW]);
      end
      out_par = cur_s[SW-1] ^ (x_in & ~cur_s[0]);
   end
endmodule

// File: rtl/ftfsm_pick.sv
module ftfsm_pick #(
   parameter int W  = 3,
   parameter int NG = 1
) (
   input  logic [W-1:0]  val_a,
   input  logic [W-1:0]  val_b,
   input  logic [NG-1:0] par_exp,
   output logic [W-1:0]  val_sel,
   output logic          flag_a,
   output logic          flag_b
);
   import ftfsm_pkg::*;

   if (NG < 1 || NG > W) begin : g_bad_ng
      $error("ftfsm_pick: NG must lie in 1..W");
   end

   logic [NG-1:0] grp_par;
   pick_e         diag;

   always_comb begin
      grp_par = '0;
      for (int i = 0; i < W; i++) grp_par[i % NG] = grp_par[i % NG] ^ val_b[i];
   end

   assign flag_a  = (val_a != val_b);
   assign flag_b  = |(grp_par ^ par_exp);
   assign diag    = pick_e'({flag_a, flag_b});
   assign val_sel = (diag == PICK_FIRSTBAD) ? val_b : val_a;
endmodule

// File: rtl/ft_state_machine.sv
module ft_state_machine #(
   parameter int          SW   = 3,
   parameter int          NG   = 1,
   parameter logic [SW-1:0] IDLE = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_bit,
   input  logic [SW-1:0]               inj_st1,
   input  logic [SW-1:0]               inj_st2,
   input  logic [SW+1:0]               inj_lg1,
   input  logic [SW+1:0]               inj_lg2,
   input  logic [NG:0]                 inj_pred,
   output logic [SW-1:0]               cur_state,
   output logic [ftfsm_pkg::OUT_W-1:0] out_bits,
   output logic                        st_flag_a,
   output logic                        st_flag_b,
   output logic                        out_flag_a,
   output logic                        out_flag_b
);
   localparam int OW = ftfsm_pkg::OUT_W;
   localparam int LW = SW + OW;

   if (SW < 2) begin : g_bad_sw
      $error("ft_state_machine: SW must be at least 2");
   end
   if (NG < 1 || NG > SW) begin : g_bad_ng
      $error("ft_state_machine: NG must lie in 1..SW");
   end

   function automatic logic [NG-1:0] grp_of(input logic [SW-1:0] v);
      logic [NG-1:0] g;
      g = '0;
      for (int i = 0; i < SW; i++) g[i % NG] = g[i % NG] ^ v[i];
      return g;
   endfunction

   logic [SW-1:0] st1_q, st2_q;
   logic [NG-1:0] par2_q;
   logic [SW-1:0] eff1, eff2;
   logic [SW-1:0] n1_raw, n2_raw, n1, n2;
   logic [OW-1:0] o1_raw, o2_raw, o1, o2;
   logic [NG-1:0] pst_raw, pst;
   logic          pout_raw, pout;

   // fault masks act on register outputs before use
   assign eff1 = st1_q ^ inj_st1;
   assign eff2 = st2_q ^ inj_st2;

   ftfsm_pick #(.W(SW), .NG(NG)) u_st_pick (
      .val_a   (eff1),
      .val_b   (eff2),
      .par_exp (par2_q),
      .val_sel (cur_state),
      .flag_a  (st_flag_a),
      .flag_b  (st_flag_b)
   );

   ftfsm_core_ref #(.SW(SW)) u_core1 (
      .cur_s (cur_state),
      .x_in  (in_bit),
      .nxt_s (n1_raw),
      .outs  (o1_raw)
   );

   ftfsm_core_split #(.SW(SW)) u_core2 (
      .cur_s (cur_state),
      .x_in  (in_bit),
      .nxt_s (n2_raw),
      .outs  (o2_raw)
   );

   ftfsm_par_pred #(.SW(SW), .NG(NG)) u_pred (
      .cur_s   (cur_state),
      .x_in    (in_bit),
      .st_par  (pst_raw),
      .out_par (pout_raw)
   );

   assign {o1, n1} = {o1_raw, n1_raw} ^ LW'(inj_lg1);
   assign {o2, n2} = {o2_raw, n2_raw} ^ LW'(inj_lg2);
   assign pst      = pst_raw  ^ inj_pred[NG-1:0];
   assign pout     = pout_raw ^ inj_pred[NG];

   ftfsm_pick #(.W(OW), .NG(1)) u_out_pick (
      .val_a   (o1),
      .val_b   (o2),
      .par_exp (pout),
      .val_sel (out_bits),
      .flag_a  (out_flag_a),
      .flag_b  (out_flag_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st1_q  <= IDLE;
         st2_q  <= IDLE;
         par2_q <= grp_of(IDLE);
      end else begin
         st1_q  <= n1;
         st2_q  <= n2;
         par2_q <= pst;
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (st1_q == IDLE && st2_q == IDLE && par2_q == grp_of(IDLE)));

   // R4
   agree_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st1_q == st2_q && inj_st1 == inj_st2) |-> !st_flag_a);

   // R6
   clean_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_st1 == '0 && st1_q == st2_q && grp_of(st2_q) == par2_q) |-> cur_state == st1_q);

   // R7
   out_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_flag_a |-> out_bits == o1);

   // R8
   reload_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_lg1 == '0 && inj_lg2 == '0 && inj_pred == '0)
      |=> (st1_q == st2_q && grp_of(st2_q) == par2_q));

   // R10
   pred_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_flag_b && !st_flag_a) |-> cur_state == eff1);

endmodule

// File: tb/test_ft_state_machine.sv
module test_ft_state_machine;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_bit = 1'b0;
   logic [2:0] inj_st1 = '0, inj_st2 = '0;
   logic [4:0] inj_lg1 = '0, inj_lg2 = '0;
   logic [1:0] inj_pred = '0;
   logic [2:0] cur_state;
   logic [1:0] out_bits;
   logic       st_flag_a, st_flag_b, out_flag_a, out_flag_b;

   int total = 0;
   int bad   = 0;

   // bench model: true state, register contents, stored parity
   logic [2:0] ts = '0, m1 = '0, m2 = '0;
   logic       mp = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ft_state_machine #(.SW(SW), .NG(1)) i_ft_state_machine (
      .clk, .rst_n, .in_bit, .inj_st1, .inj_st2, .inj_lg1, .inj_lg2, .inj_pred,
      .cur_state, .out_bits, .st_flag_a, .st_flag_b, .out_flag_a, .out_flag_b
   );

   function automatic logic [2:0] f_next(input logic [2:0] s, input logic x);
      return x ? 3'(s + 3'd1) : {s[1:0], s[2]};
   endfunction

   function automatic logic [1:0] f_out(input logic [2:0] s, input logic x);
      return {s[2] ^ x, s[0] & x};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic x, input logic [2:0] i1, input logic [2:0] i2,
                       input logic [4:0] l1, input logic [4:0] l2, input logic [1:0] pr);
      logic [2:0] e1, e2, nx;
      logic [1:0] eo, o1, o2;
      @(negedge clk);
      in_bit = x; inj_st1 = i1; inj_st2 = i2; inj_lg1 = l1; inj_lg2 = l2; inj_pred = pr;
      #1;
      e1 = m1 ^ i1;
      e2 = m2 ^ i2;
      eo = f_out(ts, x);
      o1 = eo ^ l1[4:3];
      o2 = eo ^ l2[4:3];
      chk("R2/R6 cur_state", int'(cur_state), int'(ts));
      chk("R3/R7 out_bits", int'(out_bits), int'(eo));
      chk("R4 st_flag_a", int'(st_flag_a), int'(e1 != e2));
      chk("R5 st_flag_b", int'(st_flag_b), int'((^e2) != mp));
      chk("R7 out_flag_a", int'(out_flag_a), int'(o1 != o2));
      chk("R7/R10 out_flag_b", int'(out_flag_b), int'((^o2) != ((^eo) ^ pr[1])));
      nx = f_next(ts, x);
      m1 = nx ^ l1[2:0];
      m2 = nx ^ l2[2:0];
      mp = (^nx) ^ pr[0];
      ts = nx;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      // R1: reset state
      #(CLK_PERIOD * 2 + 2);
      chk("R1 cur_state", int'(cur_state), 0);
      chk("R1 flags", int'({st_flag_a, st_flag_b, out_flag_a, out_flag_b}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 cur_state after release", int'(cur_state), 0);

      // R2: idle holds with input 0
      for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      // R2: increment through wrap
      for (int k = 0; k < 9; k++) step(1'b1, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      // R2: rotate
      for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);

      // R6: upset in register 1, then R8: flags clear next cycle
      step(1'b1, 3'b100, 3'd0, 5'd0, 5'd0, 2'd0);
      step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      // R6: upset in register 2
      step(1'b1, 3'd0, 3'b001, 5'd0, 5'd0, 2'd0);
      step(1'b1, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      // R9: next-state fault in copy 1, masked then cleared
      step(1'b1, 3'd0, 3'd0, 5'b00010, 5'd0, 2'd0);
      step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      // R9: next-state fault in copy 2
      step(1'b1, 3'd0, 3'd0, 5'd0, 5'b00100, 2'd0);
      step(1'b1, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);
      // R7: output faults in each copy
      step(1'b1, 3'd0, 3'd0, 5'b01000, 5'd0, 2'd0);
      step(1'b1, 3'd0, 3'd0, 5'd0, 5'b10000, 2'd0);
      // R10: predictor faults
      step(1'b1, 3'd0, 3'd0, 5'd0, 5'd0, 2'b01);
      step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'b10);
      step(1'b0, 3'd0, 3'd0, 5'd0, 5'd0, 2'd0);

      // random single faults, only when the model registers are clean
      for (int k = 0; k < 400; k++) begin
         logic [2:0] i1, i2;
         logic [4:0] l1, l2;
         logic [1:0] pr;
         logic       x;
         int         kind;
         i1 = '0; i2 = '0; l1 = '0; l2 = '0; pr = '0;
         x = 1'($urandom % 2);
         kind = (m1 == ts && m2 == ts && mp == ^ts) ? int'($urandom % 7) : 0;
         case (kind)
            2: i1 = 3'(1 << ($urandom % 3));
            3: i2 = 3'(1 << ($urandom % 3));
            4: l1 = 5'(1 << ($urandom % 5));
            5: l2 = 5'(1 << ($urandom % 5));
            6: pr = 2'(1 << ($urandom % 2));
            default: ;
         endcase
         step(x, i1, i2, l1, l2, pr);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule